// File: doc/BRIEF.md
# Serial Port Word Buffers with Threshold Interrupts

This block holds the words that flow between a processor-side word port and a serial shift engine. Outgoing words written by the processor queue in a transmit ring; the engine takes them one at a time, always seeing the oldest queued word on a show-ahead output. Incoming words completed by the engine queue in a receive ring; the processor reads them back, oldest first, through a read path that can sign-extend a narrow word to the full read width.

Around the two rings the block reports how many words each holds and whether each is full or empty. It shows whether the shift engine is idle and whether any transmit work remains. It raises one transmit and one receive interrupt request, each chosen by a two-bit mode select. It keeps two sticky error flags: one for an engine request on an empty transmit ring, and one for a word lost because the receive ring was full. The ring depth follows from the word width, so one ring always holds the same number of bits.

Top module: `spi_buffer_pair`

## Requirements
- R1: Each ring delivers words in the order they were accepted and wraps around its storage without loss. The engine sees the oldest transmit word on `eng_tx_data`, and the processor sees the oldest receive word on `cpu_rd_data`.
- R2: A processor write while the transmit ring is full is dropped. The count stays at the depth and the stored words are unchanged.
- R3: An engine push while the receive ring is full discards the new word and keeps the stored words. It sets `rx_overflow`, which then stays set until a cycle with `rov_clr` high and no new overflow.
- R4: An engine pop request while the transmit ring is empty sets `tx_underrun`, which stays set until a cycle with `tur_clr` high and no new underrun.
- R5: `tx_count` and `rx_count` give the number of words held. The four full/empty outputs follow those counts, and all of them are zero or empty after reset.
- R6: The transmit request `tx_irq` follows `tx_mode`. Mode 3 asserts while at least one entry is free. Mode 2 asserts while at most half the entries hold data. Mode 1 asserts while the ring is empty. Mode 0 asserts while the ring is empty and `eng_shifting` is low.
- R7: The receive request `rx_irq` follows `rx_mode`. Mode 3 asserts while the ring is full. Mode 2 asserts while it holds at least half its depth. Mode 1 asserts while it holds any word.
- R8: In receive mode 0, `rx_irq` rises in the cycle after a processor read removes the last word. It stays high until the next accepted engine push, and it is low after reset.
- R9: When `sign_ext` is high, `cpu_rd_data` repeats bit WORD_W-1 of the oldest word in every upper bit. When `sign_ext` is low, the upper bits are zero.
- R10: `sr_empty` is the inverse of `eng_shifting`. `busy` is high while the engine is shifting or the transmit ring holds a word.
- R11: The ring depth is 16 for 8-bit words, 8 for 16-bit words and 4 for 32-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Processor writes a word into the transmit ring |
| cpu_wr_data | input | WORD_W | Word to transmit |
| cpu_rd_en | input | 1 | Processor removes the oldest receive word |
| sign_ext | input | 1 | Sign-extend the read word |
| cpu_rd_data | output | RD_W | Oldest receive word, extended to RD_W |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit word |
| eng_tx_data | output | WORD_W | Oldest transmit word (show-ahead) |
| eng_rx_push | input | 1 | Engine delivers a completed word |
| eng_rx_data | input | WORD_W | Completed word from the engine |
| eng_shifting | input | 1 | Engine shift register holds a word in flight |
| tx_mode | input | 2 | Transmit interrupt condition select |
| rx_mode | input | 2 | Receive interrupt condition select |
| rov_clr | input | 1 | Clears the receive overflow flag |
| tur_clr | input | 1 | Clears the transmit underrun flag |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |
| tx_count | output | CW | Words in the transmit ring |
| rx_count | output | CW | Words in the receive ring |
| tx_full | output | 1 | Transmit ring full |
| tx_empty | output | 1 | Transmit ring empty |
| rx_full | output | 1 | Receive ring full |
| rx_empty | output | 1 | Receive ring empty |
| sr_empty | output | 1 | Shift engine idle |
| busy | output | 1 | Transfer activity pending |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| tx_underrun | output | 1 | Sticky transmit underrun flag |

## Verification
The bench builds the block with 8-bit words and a 32-bit read port. That gives the deepest rings, 16 entries, so the pointers wrap many times during the random phase, and the half threshold falls at 8 entries, well away from both empty and full. The 24 upper bits of the read path make the difference between sign extension and zero extension visible on every read. With the default 16-bit words, the same logic elaborates with 8-entry rings.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;

   typedef enum logic [1:0] {
      TXI_DONE  = 2'b00,
      TXI_EMPTY = 2'b01,
      TXI_HALF  = 2'b10,
      TXI_ROOM  = 2'b11
   } tx_irq_mode_e;

   typedef enum logic [1:0] {
      RXI_DRAINED = 2'b00,
      RXI_ANY     = 2'b01,
      RXI_HALF    = 2'b10,
      RXI_FULL    = 2'b11
   } rx_irq_mode_e;

   // ring depth chosen so that one ring always stores 128 bits
   function automatic int depth_for_width(input int w);
      if (w == 8)       return 16;
      else if (w == 16) return 8;
      else              return 4;
   endfunction

endpackage

// File: rtl/sbuf_ring.sv
module sbuf_ring #(
   parameter int W     = 8,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count
);

   if ((1 << PW) != DEPTH) begin : g_bad_depth
      $error("sbuf_ring: DEPTH must be a power of two");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wr_ptr;
   logic [PW-1:0] rd_ptr;

   // pointers wrap naturally because DEPTH is a power of two
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PW'(1);
         if (pop)  rd_ptr <= rd_ptr + PW'(1);
         count <= count + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= push_data;
   end

   assign head = mem[rd_ptr];

   a_r2_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> count < CW'(DEPTH));

   a_r4_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> count != '0);

   a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   a_r5_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop) |=> count == $past(count) + CW'(1));

   a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> count == $past(count) - CW'(1));

endmodule

// File: rtl/sbuf_tx_irq.sv
module sbuf_tx_irq
   import spi_buf_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic [1:0]    mode,
   input  logic [CW-1:0] count,
   input  logic          shifting,
   output logic          irq
);

   tx_irq_mode_e sel;
   assign sel = tx_irq_mode_e'(mode);

   always_comb begin
      unique case (sel)
         TXI_ROOM:  irq = count < CW'(DEPTH);
         TXI_HALF:  irq = count <= CW'(DEPTH / 2);
         TXI_EMPTY: irq = count == '0;
         TXI_DONE:  irq = (count == '0) && !shifting;
         default:   irq = 1'b0;
      endcase
   end

endmodule

// File: rtl/sbuf_rx_irq.sv
module sbuf_rx_irq
   import spi_buf_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    mode,
   input  logic [CW-1:0] count,
   input  logic          push_acc,
   input  logic          pop_acc,
   output logic          irq
);

   rx_irq_mode_e sel;
   logic         drained;

   assign sel = rx_irq_mode_e'(mode);

   // set by the read that takes the last word, cleared by the next arrival
   always_ff @(posedge clk) begin
      if (!rst_n)                             drained <= 1'b0;
      else if (push_acc)                      drained <= 1'b0;
      else if (pop_acc && count == CW'(1))    drained <= 1'b1;
   end

   always_comb begin
      unique case (sel)
         RXI_FULL:    irq = count == CW'(DEPTH);
         RXI_HALF:    irq = count >= CW'(DEPTH / 2);
         RXI_ANY:     irq = count != '0;
         RXI_DRAINED: irq = drained;
         default:     irq = 1'b0;
      endcase
   end

   a_r8_drained_means_empty: assert property (@(posedge clk) disable iff (!rst_n)
      drained |-> count == '0);

   a_r8_drain_on_last_read: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_acc && !push_acc && count == CW'(1)) |=> drained);

endmodule

// File: rtl/spi_buffer_pair.sv
module spi_buffer_pair
   import spi_buf_pkg::*;
#(
   parameter int  WORD_W = 16,
   parameter int  RD_W   = 32,
   localparam int DEPTH  = depth_for_width(WORD_W),
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_en,
   input  logic [WORD_W-1:0] cpu_wr_data,
   input  logic              cpu_rd_en,
   input  logic              sign_ext,
   output logic [RD_W-1:0]   cpu_rd_data,
   input  logic              eng_tx_pop,
   output logic [WORD_W-1:0] eng_tx_data,
   input  logic              eng_rx_push,
   input  logic [WORD_W-1:0] eng_rx_data,
   input  logic              eng_shifting,
   input  logic [1:0]        tx_mode,
   input  logic [1:0]        rx_mode,
   input  logic              rov_clr,
   input  logic              tur_clr,
   output logic              tx_irq,
   output logic              rx_irq,
   output logic [CW-1:0]     tx_count,
   output logic [CW-1:0]     rx_count,
   output logic              tx_full,
   output logic              tx_empty,
   output logic              rx_full,
   output logic              rx_empty,
   output logic              sr_empty,
   output logic              busy,
   output logic              rx_overflow,
   output logic              tx_underrun
);

   if (!(WORD_W == 8 || WORD_W == 16 || WORD_W == 32)) begin : g_bad_width
      $error("spi_buffer_pair: WORD_W must be 8, 16 or 32");
   end
   if (RD_W < WORD_W) begin : g_bad_read
      $error("spi_buffer_pair: RD_W must not be narrower than WORD_W");
   end

   logic              tx_push, tx_pop, rx_push, rx_pop;
   logic [WORD_W-1:0] rx_head;

   // transmit side
   assign tx_full  = tx_count == CW'(DEPTH);
   assign tx_empty = tx_count == '0;
   assign tx_push  = cpu_wr_en && !tx_full;
   assign tx_pop   = eng_tx_pop && !tx_empty;

   sbuf_ring #(.W(WORD_W), .DEPTH(DEPTH)) u_tx_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (tx_push),
      .push_data (cpu_wr_data),
      .pop       (tx_pop),
      .head      (eng_tx_data),
      .count     (tx_count)
   );

   sbuf_tx_irq #(.DEPTH(DEPTH)) u_tx_irq (
      .mode     (tx_mode),
      .count    (tx_count),
      .shifting (eng_shifting),
      .irq      (tx_irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                     tx_underrun <= 1'b0;
      else if (eng_tx_pop && tx_empty) tx_underrun <= 1'b1;
      else if (tur_clr)               tx_underrun <= 1'b0;
   end

   // receive side
   assign rx_full  = rx_count == CW'(DEPTH);
   assign rx_empty = rx_count == '0;
   assign rx_push  = eng_rx_push && !rx_full;
   assign rx_pop   = cpu_rd_en && !rx_empty;

   sbuf_ring #(.W(WORD_W), .DEPTH(DEPTH)) u_rx_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (rx_push),
      .push_data (eng_rx_data),
      .pop       (rx_pop),
      .head      (rx_head),
      .count     (rx_count)
   );

   sbuf_rx_irq #(.DEPTH(DEPTH)) u_rx_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (rx_mode),
      .count    (rx_count),
      .push_acc (rx_push),
      .pop_acc  (rx_pop),
      .irq      (rx_irq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                      rx_overflow <= 1'b0;
      else if (eng_rx_push && rx_full) rx_overflow <= 1'b1;
      else if (rov_clr)                rx_overflow <= 1'b0;
   end

   if (RD_W > WORD_W) begin : g_extend
      assign cpu_rd_data = sign_ext
         ? {{(RD_W - WORD_W){rx_head[WORD_W-1]}}, rx_head}
         : {{(RD_W - WORD_W){1'b0}}, rx_head};
   end else begin : g_same
      assign cpu_rd_data = rx_head;
   end

   // engine status
   assign sr_empty = !eng_shifting;
   assign busy     = eng_shifting || !tx_empty;

   a_r2_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr_en && tx_full && !eng_tx_pop) |=> tx_count == CW'(DEPTH));

   a_r3_overflow_keeps_ring: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_rx_push && rx_full && !cpu_rd_en) |=> (rx_count == CW'(DEPTH) && rx_overflow));

   a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_overflow && !rov_clr) |=> rx_overflow);

   a_r4_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_underrun && !tur_clr) |=> tx_underrun);

   a_r4_underrun_on_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_tx_pop && tx_empty) |=> tx_underrun);

   a_r6_no_room_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mode == 2'b11 && tx_full) |-> !tx_irq);

   a_r7_full_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_mode == 2'b11 && rx_full) |-> rx_irq);

   a_r10_busy_with_data: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_count != '0) |-> busy);

endmodule

// File: tb/spi_buffer_pair_tb.sv
`timescale 1ns/1ps
module spi_buffer_pair_tb_top;

   localparam int WW = 8;
   localparam int RW = 32;
   localparam int D  = 16;
   localparam int CW = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cpu_wr_en, cpu_rd_en, sign_ext;
   logic [WW-1:0] cpu_wr_data;
   logic [RW-1:0] cpu_rd_data;
   logic          eng_tx_pop, eng_rx_push, eng_shifting;
   logic [WW-1:0] eng_tx_data, eng_rx_data;
   logic [1:0]    tx_mode, rx_mode;
   logic          rov_clr, tur_clr;
   logic          tx_irq, rx_irq;
   logic [CW-1:0] tx_count, rx_count;
   logic          tx_full, tx_empty, rx_full, rx_empty;
   logic          sr_empty, busy, rx_overflow, tx_underrun;

   always #2.5 clk = ~clk;

   spi_buffer_pair #(.WORD_W(WW), .RD_W(RW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
      .cpu_rd_en(cpu_rd_en), .sign_ext(sign_ext), .cpu_rd_data(cpu_rd_data),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .eng_shifting(eng_shifting),
      .tx_mode(tx_mode), .rx_mode(rx_mode),
      .rov_clr(rov_clr), .tur_clr(tur_clr),
      .tx_irq(tx_irq), .rx_irq(rx_irq),
      .tx_count(tx_count), .rx_count(rx_count),
      .tx_full(tx_full), .tx_empty(tx_empty),
      .rx_full(rx_full), .rx_empty(rx_empty),
      .sr_empty(sr_empty), .busy(busy),
      .rx_overflow(rx_overflow), .tx_underrun(tx_underrun)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   logic [WW-1:0] txq[$];
   logic [WW-1:0] rxq[$];
   bit m_ovf, m_tur, m_drained;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic exp_tx_irq(input logic [1:0] m, input int n, input logic sh);
      case (m)
         2'b11:   return n < D;
         2'b10:   return n <= D / 2;
         2'b01:   return n == 0;
         default: return (n == 0) && !sh;
      endcase
   endfunction

   function automatic logic exp_rx_irq(input logic [1:0] m, input int n, input bit drn);
      case (m)
         2'b11:   return n == D;
         2'b10:   return n >= D / 2;
         2'b01:   return n != 0;
         default: return drn;
      endcase
   endfunction

   function automatic logic [RW-1:0] exp_rd(input logic [WW-1:0] w, input logic sx);
      if (sx) return {{(RW - WW){w[WW-1]}}, w};
      return {{(RW - WW){1'b0}}, w};
   endfunction

   task automatic compare_all();
      chk("R5", "tx_count", 32'(tx_count), 32'(txq.size()));
      chk("R5", "rx_count", 32'(rx_count), 32'(rxq.size()));
      chk("R5", "tx_full/empty", {30'd0, tx_full, tx_empty},
          {30'd0, txq.size() == D, txq.size() == 0});
      chk("R5", "rx_full/empty", {30'd0, rx_full, rx_empty},
          {30'd0, rxq.size() == D, rxq.size() == 0});
      chk("R4", "tx_underrun", 32'(tx_underrun), 32'(m_tur));
      chk("R3", "rx_overflow", 32'(rx_overflow), 32'(m_ovf));
      chk("R6", "tx_irq", 32'(tx_irq), 32'(exp_tx_irq(tx_mode, txq.size(), eng_shifting)));
      if (rx_mode == 2'b00)
         chk("R8", "rx_irq drained", 32'(rx_irq), 32'(m_drained));
      else
         chk("R7", "rx_irq", 32'(rx_irq), 32'(exp_rx_irq(rx_mode, rxq.size(), m_drained)));
      chk("R10", "busy/sr_empty", {30'd0, busy, sr_empty},
          {30'd0, eng_shifting || txq.size() != 0, !eng_shifting});
      if (txq.size() != 0) chk("R1", "eng_tx_data", 32'(eng_tx_data), 32'(txq[0]));
      if (rxq.size() != 0) chk("R1 R9", "cpu_rd_data", cpu_rd_data, exp_rd(rxq[0], sign_ext));
   endtask

   // inputs are set by the caller at a falling edge; one rising edge follows
   task automatic step();
      int tn = txq.size();
      int rn = rxq.size();
      if (eng_tx_pop && tn == 0) m_tur = 1;
      else if (tur_clr)          m_tur = 0;
      if (eng_rx_push && rn == D) m_ovf = 1;
      else if (rov_clr)           m_ovf = 0;
      if (eng_rx_push && rn < D)               m_drained = 0;
      else if (cpu_rd_en && rn == 1)           m_drained = 1;
      if (eng_tx_pop && tn > 0) void'(txq.pop_front());
      if (cpu_wr_en && tn < D)  txq.push_back(cpu_wr_data);
      if (cpu_rd_en && rn > 0)  void'(rxq.pop_front());
      if (eng_rx_push && rn < D) rxq.push_back(eng_rx_data);
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle();
      cpu_wr_en = 0; cpu_rd_en = 0; eng_tx_pop = 0; eng_rx_push = 0;
      rov_clr = 0; tur_clr = 0;
   endtask

   initial begin
      #1000000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      idle();
      cpu_wr_data = '0; eng_rx_data = '0; sign_ext = 0; eng_shifting = 0;
      tx_mode = 2'b00; rx_mode = 2'b00;
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // reset state R5, R8
      compare_all();
      chk("R8", "rx_irq low after reset", 32'(rx_irq), 32'd0);

      // fill the transmit ring, then overfill (R2, R11)
      for (int i = 0; i < D + 2; i++) begin
         cpu_wr_en = 1; cpu_wr_data = WW'(i * 7 + 3);
         step();
      end
      idle();
      chk("R11", "tx depth", 32'(tx_count), 32'(D));
      chk("R2", "oldest word kept", 32'(eng_tx_data), 32'd3);
      for (int m = 0; m < 4; m++) begin
         tx_mode = 2'(m); eng_shifting = 1;
         #1; compare_all();
      end
      // drain with irq mode half (R1, R6)
      tx_mode = 2'b10;
      for (int i = 0; i < D; i++) begin
         eng_tx_pop = 1; step();
      end
      // underrun and its stickiness (R4)
      step();
      chk("R4", "underrun set", 32'(tx_underrun), 32'd1);
      idle(); step(); step();
      chk("R4", "underrun held", 32'(tx_underrun), 32'd1);
      tur_clr = 1; step(); idle();
      chk("R4", "underrun cleared", 32'(tx_underrun), 32'd0);
      eng_shifting = 0; tx_mode = 2'b00; #1; compare_all();

      // fill receive ring, then overflow (R3, R7, R11)
      rx_mode = 2'b11;
      for (int i = 0; i < D; i++) begin
         eng_rx_push = 1; eng_rx_data = WW'(8'h80 + i * 5);
         step();
      end
      chk("R11", "rx depth", 32'(rx_count), 32'(D));
      eng_rx_data = 8'h11; step();
      idle();
      chk("R3", "overflow flag", 32'(rx_overflow), 32'd1);
      chk("R3", "stored word kept", cpu_rd_data, exp_rd(8'h80, 1'b0));
      step();
      chk("R3", "overflow held", 32'(rx_overflow), 32'd1);
      rov_clr = 1; step(); idle();
      // read all with sign extension toggling (R1, R9), drained irq (R8)
      rx_mode = 2'b00;
      for (int i = 0; i < D; i++) begin
         sign_ext = i[0]; #1; compare_all();
         cpu_rd_en = 1; step();
      end
      idle();
      chk("R8", "drained irq", 32'(rx_irq), 32'd1);
      eng_rx_push = 1; eng_rx_data = 8'hF3; step(); idle();
      chk("R8", "drained clears", 32'(rx_irq), 32'd0);
      sign_ext = 1; #1;
      chk("R9", "sign extended", cpu_rd_data, 32'hFFFF_FFF3);
      sign_ext = 0; #1;
      chk("R9", "zero extended", cpu_rd_data, 32'h0000_00F3);

      // constrained random traffic
      for (int c = 0; c < 4000; c++) begin
         if (c % 97 == 0) begin
            tx_mode = 2'($urandom_range(0, 3));
            rx_mode = 2'($urandom_range(0, 3));
         end
         cpu_wr_en    = ($urandom_range(0, 99) < 45);
         cpu_wr_data  = WW'($urandom);
         eng_tx_pop   = ($urandom_range(0, 99) < 40);
         eng_rx_push  = ($urandom_range(0, 99) < 45);
         eng_rx_data  = WW'($urandom);
         cpu_rd_en    = ($urandom_range(0, 99) < 40);
         eng_shifting = ($urandom_range(0, 1) == 1);
         sign_ext     = ($urandom_range(0, 1) == 1);
         rov_clr      = ($urandom_range(0, 99) < 4);
         tur_clr      = ($urandom_range(0, 99) < 4);
         step();
      end
      idle();
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule